// File: doc/BRIEF.md
# Wide Store Sequencer

This block sits in the store path of a simple in-order core with 32-bit registers. It takes a decoded store instruction, its effective address and the source register value. A store wider than the register file becomes a short run of 32-bit write beats on a single data-memory write port. A doubleword store takes two beats and a quadword store takes four. Only the first beat carries the register value. The later beats write zeros, which matches a core whose upper register halves are architecturally zero.

The block also checks the alignment of every store class it sees. A misaligned word, halfword, doubleword or quadword store raises a one-cycle store address-error fault and writes nothing. Aligned word and halfword stores are handled by another part of the core, so this block only checks their alignment. While a wide store is running, the block ignores new requests. The issuing stage holds off until the retire pulse.

Top module: `wide_store_seq`

## Requirements
- R1: While reset is asserted, and until the first request after reset, `mem_we`, `retire` and `fault` are 0, and `mem_addr` and `mem_wdata` are 0.
- R2: Opcode 6'h3F is the doubleword store and produces exactly 2 consecutive write beats. Opcode 6'h1F is the quadword store and produces exactly 4. Beat 0 appears in the cycle after the request is sampled.
- R3: Beat n writes to address (ea with bits [1:0] cleared) + 4*n, so successive beats hit successive 32-bit words.
- R4: `mem_wdata` equals the sampled `rt_val` on beat 0 and is 0 on every later beat.
- R5: `retire` is a one-cycle pulse coinciding with the final beat: beat 1 for a doubleword store and beat 3 for a quadword store.
- R6: `mem_we` is high only during write beats and low in every other cycle.
- R7: A misaligned request raises `fault` for one cycle in the cycle after it is sampled, with no write and no retire. The alignment rules are: doubleword with ea[2:0]!=0, quadword with ea[3:0]!=0, word (6'h2B) with ea[1:0]!=0, halfword (6'h29) with ea[0]!=0.
- R8: A doubleword store of 0xABCD1234 to 0x400 leaves 0xABCD1234 at 0x400 and 0 at 0x404, replacing whatever was there before.
- R9: A request presented while beats are in progress is ignored. It changes no beat, raises no fault and starts no later sequence.
- R10: An aligned word or halfword store, or any other opcode, causes no write, no retire and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | A decoded store is presented this cycle |
| opcode | input | 6 | Primary opcode of the store |
| ea | input | 32 | Effective byte address |
| rt_val | input | 32 | Source register value |
| mem_addr | output | 32 | Byte address of the current write beat |
| mem_wdata | output | 32 | Data of the current write beat |
| mem_we | output | 1 | Write enable for the current beat |
| retire | output | 1 | One-cycle pulse on the final beat |
| fault | output | 1 | One-cycle store address-error pulse |

## Verification
The bench targets the point where the shared counter must stop at a different beat for each store width. A design that confused the two would emit four beats for a doubleword store or retire a quadword store halfway. It checks that zeros reach the upper beats. A design that repeated the register value there would corrupt the word at 0x404 in the overwrite case. It drives the alignment boundaries that separate the store classes, such as a quadword at an address that is only doubleword aligned. A wrong mask would then either fault legal stores or write misaligned ones. Requests arriving mid-sequence are also driven, and a design that accepted them would restart the counter or raise stray faults.

// File: rtl/wss_pkg.sv
package wss_pkg;

  localparam logic [5:0] OPC_HALF  = 6'h29;
  localparam logic [5:0] OPC_WORD  = 6'h2B;
  localparam logic [5:0] OPC_QWORD = 6'h1F;
  localparam logic [5:0] OPC_DWORD = 6'h3F;

  localparam int ALIGN_W = 4;

  typedef enum logic [2:0] {
    K_NONE,
    K_HALF,
    K_WORD,
    K_DWORD,
    K_QWORD
  } st_kind_e;

  typedef enum logic {
    S_IDLE,
    S_WRITE
  } seq_state_e;

  // Low address bits that must be zero for each store class
  function automatic logic [ALIGN_W-1:0] align_mask(st_kind_e k);
    case (k)
      K_HALF:  return 4'b0001;
      K_WORD:  return 4'b0011;
      K_DWORD: return 4'b0111;
      K_QWORD: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  // Index of the last write beat of a wide store
  function automatic logic [1:0] final_beat(st_kind_e k);
    case (k)
      K_DWORD: return 2'd1;
      K_QWORD: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/wss_decode.sv
module wss_decode
  import wss_pkg::*;
(
  input  logic [5:0]         opcode,
  input  logic [ALIGN_W-1:0] ea_lo,
  output st_kind_e           kind,
  output logic               wide,
  output logic               misaligned
);

  always_comb begin
    case (opcode)
      OPC_HALF:  kind = K_HALF;
      OPC_WORD:  kind = K_WORD;
      OPC_DWORD: kind = K_DWORD;
      OPC_QWORD: kind = K_QWORD;
      default:   kind = K_NONE;
    endcase
  end

  always_comb begin
    wide       = (kind == K_DWORD) || (kind == K_QWORD);
    misaligned = |(ea_lo & align_mask(kind));
  end

endmodule

// File: rtl/wss_beat_ctr.sv
module wss_beat_ctr
  import wss_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BEAT_W-1:0] last_in,
  output logic              busy,
  output logic [BEAT_W-1:0] beat,
  output logic              final_beat_o
);

  seq_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [BEAT_W-1:0] last_q;
  logic              beat_en;

  assign busy         = (state_q == S_WRITE);
  assign beat         = beat_q;
  assign final_beat_o = busy && (beat_q == last_q);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (start) state_d = S_WRITE;
      S_WRITE: if (final_beat_o) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    beat_en = start || (busy && !final_beat_o);
    beat_d  = start ? '0 : beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      beat_q  <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      if (beat_en) beat_q <= beat_d;
      if (start)   last_q <= last_in;
    end
  end

  AST_LAST_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    final_beat_o |=> !busy); // R5
  AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !final_beat_o) |=> (busy && beat == $past(beat) + 1'b1)); // R2
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (beat == '0)); // R2

endmodule

// File: rtl/wss_datapath.sv
module wss_datapath #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-3:0] ea_word,
  input  logic [DATA_W-1:0] rt_val,
  input  logic              busy,
  input  logic [BEAT_W-1:0] beat,
  input  logic              last_beat,
  input  logic              fault_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              retire,
  output logic              fault
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] base_q;
  logic [DATA_W-1:0] data_q;
  logic              fault_q;
  logic [WIDX_W-1:0] word_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      data_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      if (capture) begin
        base_q <= ea_word;
        data_q <= rt_val;
      end
      fault_q <= fault_in;
    end
  end

  always_comb begin
    word_idx  = base_q + WIDX_W'(beat);
    mem_we    = busy;
    mem_addr  = busy ? {word_idx, 2'b00} : '0;
    mem_wdata = (busy && beat == '0) ? data_q : '0;
    retire    = last_beat;
    fault     = fault_q;
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !retire) |=> (mem_we && mem_addr == $past(mem_addr) + ADDR_W'(4))); // R3
  AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire); // R5
  AST_RETIRE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> mem_we); // R6
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_we && !retire)); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && !$past(retire)) |-> (mem_wdata == '0)); // R4

endmodule

// File: rtl/wide_store_seq.sv
module wide_store_seq
  import wss_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [5:0]        opcode,
  input  logic [ADDR_W-1:0] ea,
  input  logic [DATA_W-1:0] rt_val,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              retire,
  output logic              fault
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  st_kind_e          kind;
  logic              wide;
  logic              misaligned;
  logic              busy;
  logic              last_beat;
  logic [BEAT_W-1:0] beat;
  logic              accept;
  logic              start;
  logic              fault_in;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  wss_decode u_decode (
    .opcode     (opcode),
    .ea_lo      (ea[ALIGN_W-1:0]),
    .kind       (kind),
    .wide       (wide),
    .misaligned (misaligned)
  );

  always_comb begin
    accept   = issue_valid && !busy;
    start    = accept && wide && !misaligned;
    fault_in = accept && misaligned;
  end

  wss_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .start        (start),
    .last_in      (BEAT_W'(final_beat(kind))),
    .busy         (busy),
    .beat         (beat),
    .final_beat_o (last_beat)
  );

  wss_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .capture   (start),
    .ea_word   (ea[ADDR_W-1:2]),
    .rt_val    (rt_val),
    .busy      (busy),
    .beat      (beat),
    .last_beat (last_beat),
    .fault_in  (fault_in),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .retire    (retire),
    .fault     (fault)
  );

  AST_BUSY_BLOCKS_FAULT: assert property (@(posedge clk) disable iff (!rst_n_int)
    (issue_valid && busy) |=> !fault); // R9
  AST_FAULT_NO_START: assert property (@(posedge clk) disable iff (!rst_n_int)
    fault |-> !$rose(mem_we)); // R7

endmodule

// File: tb/wide_store_seq_bench.sv
module wide_store_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        issue_valid = 1'b0;
  logic [5:0]  opcode = '0;
  logic [31:0] ea = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_we, retire, fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit          m_busy = 0;
  int          m_cnt = 0;
  int          m_last = 0;
  logic [31:0] m_base = '0;
  logic [31:0] m_rt = '0;
  bit          m_fault = 0;

  // observation counters
  int obs_we = 0, obs_ret = 0, obs_fault = 0;
  logic [31:0] bmem [logic [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_store_seq u_wide_store_seq (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
    .ea(ea), .rt_val(rt_val), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .retire(retire), .fault(fault)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic classify(input logic [5:0] op, output int mask, output int last, output bit wide);
    mask = 0; last = 0; wide = 0;
    if (op == 6'h29) mask = 1;
    else if (op == 6'h2B) mask = 3;
    else if (op == 6'h3F) begin mask = 7; last = 1; wide = 1; end
    else if (op == 6'h1F) begin mask = 15; last = 3; wide = 1; end
  endtask

  task automatic model_update();
    int mask, last; bit wide; bit nf;
    nf = 0;
    if (m_busy) begin
      if (m_cnt == m_last) m_busy = 0;
      else m_cnt++;
    end else if (issue_valid) begin
      classify(opcode, mask, last, wide);
      if ((ea & mask) != 0) nf = 1;
      else if (wide) begin
        m_busy = 1; m_cnt = 0; m_last = last;
        m_base = ea & 32'hFFFF_FFFC; m_rt = rt_val;
      end
    end
    m_fault = nf;
  endtask

  task automatic compare();
    chk("R6", "mem_we", {31'd0, mem_we}, {31'd0, m_busy});
    chk("R3", "mem_addr", mem_addr, m_busy ? m_base + 32'(4 * m_cnt) : 32'd0);
    chk("R4", "mem_wdata", mem_wdata, (m_busy && m_cnt == 0) ? m_rt : 32'd0);
    chk("R5", "retire", {31'd0, retire}, {31'd0, (m_busy && m_cnt == m_last)});
    chk("R7", "fault", {31'd0, fault}, {31'd0, m_fault});
    if (mem_we) begin obs_we++; bmem[mem_addr] = mem_wdata; end
    if (retire) obs_ret++;
    if (fault) obs_fault++;
  endtask

  task automatic step(bit v, logic [5:0] op, logic [31:0] a, logic [31:0] r);
    issue_valid = v; opcode = op; ea = a; rt_val = r;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 6'h00, 32'h0, 32'h0);
  endtask

  task automatic clr_obs();
    obs_we = 0; obs_ret = 0; obs_fault = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2 rst_n = 1'b0;
    @(negedge clk);
    // R1: outputs quiet under reset
    chk("R1", "we_in_reset", {31'd0, mem_we}, 32'd0);
    chk("R1", "ret_in_reset", {31'd0, retire}, 32'd0);
    chk("R1", "fault_in_reset", {31'd0, fault}, 32'd0);
    chk("R1", "addr_in_reset", mem_addr, 32'd0);
    chk("R1", "data_in_reset", mem_wdata, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R8: doubleword overwrite of both words
    bmem[32'h400] = 32'hDEADBEEF;
    bmem[32'h404] = 32'hCAFEF00D;
    clr_obs();
    step(1, 6'h3F, 32'h400, 32'hABCD1234);
    idle(3);
    chk("R8", "mem400", bmem[32'h400], 32'hABCD1234);
    chk("R8", "mem404", bmem[32'h404], 32'h0);
    chk("R2", "dword_beats", obs_we, 2);
    chk("R5", "dword_retires", obs_ret, 1);

    // R2: quadword four beats
    clr_obs();
    step(1, 6'h1F, 32'h1000, 32'h11223344);
    idle(5);
    chk("R2", "qword_beats", obs_we, 4);
    chk("R4", "qword_upper", bmem[32'h100C], 32'h0);

    // R7: misalignment boundaries
    clr_obs();
    step(1, 6'h1F, 32'h1008, 32'h1);
    step(1, 6'h3F, 32'h404, 32'h2);
    step(1, 6'h2B, 32'h2, 32'h3);
    step(1, 6'h29, 32'h1, 32'h4);
    idle(2);
    chk("R7", "fault_count", obs_fault, 4);
    chk("R7", "no_write_on_fault", obs_we, 0);

    // R10: aligned word/halfword and foreign opcodes do nothing here
    clr_obs();
    step(1, 6'h2B, 32'h8, 32'h5);
    step(1, 6'h29, 32'h2, 32'h6);
    step(1, 6'h23, 32'h3, 32'h7);
    idle(2);
    chk("R10", "no_write", obs_we, 0);
    chk("R10", "no_retire", obs_ret, 0);
    chk("R10", "no_fault", obs_fault, 0);

    // R9: requests during beats are dropped
    clr_obs();
    step(1, 6'h1F, 32'h2000, 32'h55);
    step(1, 6'h3F, 32'h2003, 32'h66);
    step(1, 6'h3F, 32'h3000, 32'h77);
    step(1, 6'h1F, 32'h3001, 32'h88);
    idle(3);
    chk("R9", "busy_beats", obs_we, 4);
    chk("R9", "busy_no_fault", obs_fault, 0);
    chk("R9", "busy_untouched", bmem.exists(32'h3000) ? 32'h1 : 32'h0, 32'h0);

    // back-to-back held request
    for (int i = 0; i < 8; i++) step(1, 6'h3F, 32'h4000, 32'h99);
    idle(2);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [5:0] ops [5];
      ops = '{6'h3F, 6'h1F, 6'h2B, 6'h29, 6'h0C};
      step(1'($urandom_range(0, 1)), ops[$urandom_range(0, 4)],
           {$urandom_range(0, 65535), 16'h0} | 32'($urandom_range(0, 15)) << 0,
           $urandom);
    end
    idle(5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule